// File: doc/BRIEF.md
# Row-Hit-First DRAM Request Scheduler

This block orders pending memory requests for a DRAM controller with eight banks. Requests enter through a valid/ready enqueue port and wait in a small queue. Each entry holds a bank, a row, the id of the warp that issued it, and a count of how many instructions that warp still has left. The block also gives every entry an age. Every cycle it looks at the entries whose bank is not marked busy, chooses one, presents it on the issue port with a row-hit flag, and removes it from the queue on the clock edge.

The block records the open row of every bank, and an issue makes the issued row the open row of its bank. A two-bit policy input selects how entries are ranked:
- **Plain oldest-first.** Row state is ignored.
- **Open-row hits first, then age.**
- **Open-row hits first, then least-served warp.** Per-warp issue counters balance progress across warps.
- **Open-row hits first, then most remaining work.** The warp with the most instructions left wins.

Any tie left after these rules goes to the older entry, then to the lower queue slot. DRAM timing and data transfer are outside the block. The `bank_busy_i` vector stands in for bank occupancy.

Top module: `dram_req_sched`

## Requirements
- R1: `enq_ready_o` is low exactly when all QDEPTH slots are occupied. A request is accepted when `enq_valid_i` and `enq_ready_o` are both high, and it is written into the lowest-numbered free slot with age 0.
- R2: `iss_valid_o` is high exactly when at least one pending entry targets a bank whose `bank_busy_i` bit is low. Only such an entry is issued. The issued entry leaves the queue at the next clock edge.
- R3: With `policy_i`=0 (oldest-first), the issued entry is the eligible entry with the largest age, whatever the row state.
- R4: With `policy_i`=1, eligible row hits take precedence over misses. Within the chosen group the largest age wins.
- R5: With `policy_i`=2, row hits take precedence. Within the group, the entry whose warp has the smallest served count wins.
- R6: With `policy_i`=3, row hits take precedence. Within the group, the entry with the largest remaining-instruction count wins.
- R7: Ties left after the policy rules go to the larger age, then to the lower slot index.
- R8: `iss_hit_o` is high exactly when the issued entry's bank has a recorded open row equal to the issued row, under every policy. After reset no bank has an open row.
- R9: Each issue records the issued row as the open row of its bank, under every policy.
- R10: Each warp's served counter resets to 0. It increments by one on every issue from that warp and saturates at 2^SERV_W-1.
- R11: An entry's age increases by one on every clock edge it stays queued, and saturates at 2^AGE_W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| policy_i | input | 2 | 0 oldest-first, 1 hit-then-age, 2 hit-then-fair, 3 hit-then-remaining |
| bank_busy_i | input | NUM_BANKS | Per-bank occupied flag |
| enq_valid_i | input | 1 | Request offered |
| enq_ready_o | output | 1 | Queue has a free slot |
| enq_bank_i | input | BANK_W | Request bank |
| enq_row_i | input | ROW_W | Request row |
| enq_warp_i | input | WARP_W | Issuing warp id |
| enq_rem_i | input | REM_W | Warp's remaining instruction count |
| iss_valid_o | output | 1 | An entry is issued this cycle |
| iss_bank_o | output | BANK_W | Issued bank |
| iss_row_o | output | ROW_W | Issued row |
| iss_warp_o | output | WARP_W | Issued warp id |
| iss_rem_o | output | REM_W | Issued remaining count |
| iss_hit_o | output | 1 | Issued entry hits the open row |

## Verification
The assertions assume that the issue port is always consumed: any cycle with `iss_valid_o` high counts as a departure. They also assume that a request offered while `enq_ready_o` is low is simply dropped. The checker rebuilds occupancy and the open-row table from port activity alone, so it relies on these two assumptions.

The stimulus keeps rows within a small range and busy patterns partial, so hits, misses and eligible entries all occur. Long stretches with every bank busy fill the queue and drive ages into saturation. The bench's reference model keeps its own slot, age, open-row and served-count state, and it is written from the requirements above.

// File: rtl/dram_sched_pkg.sv
`timescale 1ns/1ps
package dram_sched_pkg;
  typedef enum logic [1:0] {
    POL_OLDEST = 2'd0,
    POL_HIT_AGE = 2'd1,
    POL_HIT_FAIR = 2'd2,
    POL_HIT_REM = 2'd3
  } policy_e;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/dram_sched_queue.sv
`timescale 1ns/1ps
module dram_sched_queue #(
  parameter int QDEPTH = 16,
  parameter int BANK_W = 3,
  parameter int ROW_W  = 14,
  parameter int WARP_W = 3,
  parameter int REM_W  = 12,
  parameter int AGE_W  = 8,
  localparam int IDX_W = $clog2(QDEPTH)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           enq_i,
  input  logic [BANK_W-1:0]              enq_bank_i,
  input  logic [ROW_W-1:0]               enq_row_i,
  input  logic [WARP_W-1:0]              enq_warp_i,
  input  logic [REM_W-1:0]               enq_rem_i,
  input  logic                           deq_i,
  input  logic [IDX_W-1:0]               deq_idx_i,
  output logic                           ready_o,
  output logic [QDEPTH-1:0]              vld_o,
  output logic [QDEPTH-1:0][BANK_W-1:0]  bank_o,
  output logic [QDEPTH-1:0][ROW_W-1:0]   row_o,
  output logic [QDEPTH-1:0][WARP_W-1:0]  warp_o,
  output logic [QDEPTH-1:0][REM_W-1:0]   rem_o,
  output logic [QDEPTH-1:0][AGE_W-1:0]   age_o
);
  logic [IDX_W-1:0] free_idx;
  logic             found;

  always_comb begin
    free_idx = '0;
    found    = 1'b0;
    for (int i = 0; i < QDEPTH; i++) begin
      if (!vld_o[i] && !found) begin
        free_idx = IDX_W'(i);
        found    = 1'b1;
      end
    end
  end

  assign ready_o = found;

  for (genvar g = 0; g < QDEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_o[g]  <= 1'b0;
        bank_o[g] <= '0;
        row_o[g]  <= '0;
        warp_o[g] <= '0;
        rem_o[g]  <= '0;
        age_o[g]  <= '0;
      end else if (deq_i && deq_idx_i == IDX_W'(g)) begin
        vld_o[g] <= 1'b0;
      end else if (vld_o[g]) begin
        if (age_o[g] != {AGE_W{1'b1}}) age_o[g] <= age_o[g] + 1'b1;
      end else if (enq_i && free_idx == IDX_W'(g)) begin
        vld_o[g]  <= 1'b1;
        bank_o[g] <= enq_bank_i;
        row_o[g]  <= enq_row_i;
        warp_o[g] <= enq_warp_i;
        rem_o[g]  <= enq_rem_i;
        age_o[g]  <= '0;
      end
    end
  end
endmodule

// File: rtl/dram_open_rows.sv
`timescale 1ns/1ps
module dram_open_rows #(
  parameter int NUM_BANKS = 8,
  parameter int ROW_W     = 14,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             upd_i,
  input  logic [BANK_W-1:0]                upd_bank_i,
  input  logic [ROW_W-1:0]                 upd_row_i,
  output logic [NUM_BANKS-1:0]             open_vld_o,
  output logic [NUM_BANKS-1:0][ROW_W-1:0]  open_row_o
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        open_vld_o[b] <= 1'b0;
        open_row_o[b] <= '0;
      end else if (upd_i && upd_bank_i == BANK_W'(b)) begin
        open_vld_o[b] <= 1'b1;
        open_row_o[b] <= upd_row_i;
      end
    end
  end
endmodule

// File: rtl/dram_warp_served.sv
`timescale 1ns/1ps
module dram_warp_served #(
  parameter int WARP_W   = 3,
  parameter int SERV_W   = 8,
  localparam int NUM_WARPS = 1 << WARP_W
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              inc_i,
  input  logic [WARP_W-1:0]                 inc_warp_i,
  output logic [NUM_WARPS-1:0][SERV_W-1:0]  cnt_o
);
  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_o[w] <= '0;
      end else if (inc_i && inc_warp_i == WARP_W'(w) && cnt_o[w] != {SERV_W{1'b1}}) begin
        cnt_o[w] <= cnt_o[w] + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dram_sched_pick.sv
`timescale 1ns/1ps
module dram_sched_pick
  import dram_sched_pkg::*;
#(
  parameter int QDEPTH    = 16,
  parameter int NUM_BANKS = 8,
  parameter int ROW_W     = 14,
  parameter int WARP_W    = 3,
  parameter int REM_W     = 12,
  parameter int AGE_W     = 8,
  parameter int SERV_W    = 8,
  localparam int IDX_W     = $clog2(QDEPTH),
  localparam int BANK_W    = $clog2(NUM_BANKS),
  localparam int NUM_WARPS = 1 << WARP_W,
  localparam int SEC_W     = max_int(REM_W, SERV_W),
  localparam int KEY_W     = 1 + SEC_W + AGE_W + IDX_W
) (
  input  policy_e                           policy_i,
  input  logic [NUM_BANKS-1:0]              bank_busy_i,
  input  logic [QDEPTH-1:0]                 vld_i,
  input  logic [QDEPTH-1:0][BANK_W-1:0]     bank_i,
  input  logic [QDEPTH-1:0][ROW_W-1:0]      row_i,
  input  logic [QDEPTH-1:0][WARP_W-1:0]     warp_i,
  input  logic [QDEPTH-1:0][REM_W-1:0]      rem_i,
  input  logic [QDEPTH-1:0][AGE_W-1:0]      age_i,
  input  logic [NUM_BANKS-1:0]              open_vld_i,
  input  logic [NUM_BANKS-1:0][ROW_W-1:0]   open_row_i,
  input  logic [NUM_WARPS-1:0][SERV_W-1:0]  served_i,
  output logic                              pick_vld_o,
  output logic [IDX_W-1:0]                  pick_idx_o,
  output logic                              pick_hit_o
);
  logic [QDEPTH-1:0]            elig;
  logic [QDEPTH-1:0]            hit;
  logic [QDEPTH-1:0][KEY_W-1:0] key;

  for (genvar g = 0; g < QDEPTH; g++) begin : g_key
    logic [SEC_W-1:0] sec;
    logic             hit_rank;
    assign elig[g] = vld_i[g] && !bank_busy_i[bank_i[g]];
    assign hit[g]  = open_vld_i[bank_i[g]] && (open_row_i[bank_i[g]] == row_i[g]);
    assign hit_rank = (policy_i != POL_OLDEST) && hit[g];
    always_comb begin
      unique case (policy_i)
        POL_HIT_FAIR: sec = SEC_W'(~served_i[warp_i[g]]);  // fewer served ranks higher
        POL_HIT_REM:  sec = SEC_W'(rem_i[g]);
        default:      sec = '0;
      endcase
    end
    // lower slot ranks higher on equal age
    assign key[g] = {hit_rank, sec, age_i[g], IDX_W'(QDEPTH - 1 - g)};
  end

  always_comb begin
    logic [KEY_W-1:0] best;
    best       = '0;
    pick_vld_o = 1'b0;
    pick_idx_o = '0;
    for (int i = 0; i < QDEPTH; i++) begin
      if (elig[i] && (!pick_vld_o || key[i] > best)) begin
        best       = key[i];
        pick_vld_o = 1'b1;
        pick_idx_o = IDX_W'(i);
      end
    end
    pick_hit_o = pick_vld_o && hit[pick_idx_o];
  end
endmodule

// File: rtl/dram_req_sched.sv
`timescale 1ns/1ps
module dram_req_sched
  import dram_sched_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int QDEPTH    = 16,
  parameter int ROW_W     = 14,
  parameter int WARP_W    = 3,
  parameter int REM_W     = 12,
  parameter int AGE_W     = 8,
  parameter int SERV_W    = 8,
  localparam int BANK_W    = $clog2(NUM_BANKS),
  localparam int IDX_W     = $clog2(QDEPTH),
  localparam int NUM_WARPS = 1 << WARP_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [1:0]           policy_i,
  input  logic [NUM_BANKS-1:0] bank_busy_i,
  input  logic                 enq_valid_i,
  output logic                 enq_ready_o,
  input  logic [BANK_W-1:0]    enq_bank_i,
  input  logic [ROW_W-1:0]     enq_row_i,
  input  logic [WARP_W-1:0]    enq_warp_i,
  input  logic [REM_W-1:0]     enq_rem_i,
  output logic                 iss_valid_o,
  output logic [BANK_W-1:0]    iss_bank_o,
  output logic [ROW_W-1:0]     iss_row_o,
  output logic [WARP_W-1:0]    iss_warp_o,
  output logic [REM_W-1:0]     iss_rem_o,
  output logic                 iss_hit_o
);
  logic [QDEPTH-1:0]                vld;
  logic [QDEPTH-1:0][BANK_W-1:0]    q_bank;
  logic [QDEPTH-1:0][ROW_W-1:0]     q_row;
  logic [QDEPTH-1:0][WARP_W-1:0]    q_warp;
  logic [QDEPTH-1:0][REM_W-1:0]     q_rem;
  logic [QDEPTH-1:0][AGE_W-1:0]     q_age;
  logic [NUM_BANKS-1:0]             open_vld;
  logic [NUM_BANKS-1:0][ROW_W-1:0]  open_row;
  logic [NUM_WARPS-1:0][SERV_W-1:0] served;
  logic [IDX_W-1:0]                 pick_idx;
  logic                             enq_fire;

  assign enq_fire = enq_valid_i && enq_ready_o;

  dram_sched_queue #(
    .QDEPTH(QDEPTH), .BANK_W(BANK_W), .ROW_W(ROW_W),
    .WARP_W(WARP_W), .REM_W(REM_W), .AGE_W(AGE_W)
  ) u_queue (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .enq_i(enq_fire), .enq_bank_i(enq_bank_i), .enq_row_i(enq_row_i),
    .enq_warp_i(enq_warp_i), .enq_rem_i(enq_rem_i),
    .deq_i(iss_valid_o), .deq_idx_i(pick_idx),
    .ready_o(enq_ready_o), .vld_o(vld), .bank_o(q_bank), .row_o(q_row),
    .warp_o(q_warp), .rem_o(q_rem), .age_o(q_age)
  );

  dram_open_rows #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W)) u_rows (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .upd_i(iss_valid_o), .upd_bank_i(iss_bank_o), .upd_row_i(iss_row_o),
    .open_vld_o(open_vld), .open_row_o(open_row)
  );

  dram_warp_served #(.WARP_W(WARP_W), .SERV_W(SERV_W)) u_served (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .inc_i(iss_valid_o), .inc_warp_i(iss_warp_o), .cnt_o(served)
  );

  dram_sched_pick #(
    .QDEPTH(QDEPTH), .NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .WARP_W(WARP_W),
    .REM_W(REM_W), .AGE_W(AGE_W), .SERV_W(SERV_W)
  ) u_pick (
    .policy_i(policy_e'(policy_i)), .bank_busy_i(bank_busy_i),
    .vld_i(vld), .bank_i(q_bank), .row_i(q_row), .warp_i(q_warp),
    .rem_i(q_rem), .age_i(q_age), .open_vld_i(open_vld), .open_row_i(open_row),
    .served_i(served), .pick_vld_o(iss_valid_o), .pick_idx_o(pick_idx),
    .pick_hit_o(iss_hit_o)
  );

  assign iss_bank_o = q_bank[pick_idx];
  assign iss_row_o  = q_row[pick_idx];
  assign iss_warp_o = q_warp[pick_idx];
  assign iss_rem_o  = q_rem[pick_idx];
endmodule

// File: rtl/dram_req_sched_chk.sv
`timescale 1ns/1ps
module dram_req_sched_chk #(
  parameter int NUM_BANKS = 8,
  parameter int QDEPTH    = 16,
  parameter int ROW_W     = 14,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int OCC_W    = $clog2(QDEPTH) + 1
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [NUM_BANKS-1:0] bank_busy_i,
  input logic                 enq_valid_i,
  input logic                 enq_ready_o,
  input logic                 iss_valid_o,
  input logic [BANK_W-1:0]    iss_bank_o,
  input logic [ROW_W-1:0]     iss_row_o,
  input logic                 iss_hit_o
);
  logic [OCC_W-1:0]                occ;
  logic [NUM_BANKS-1:0]            ck_vld;
  logic [NUM_BANKS-1:0][ROW_W-1:0] ck_row;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      occ    <= '0;
      ck_vld <= '0;
      ck_row <= '0;
    end else begin
      occ <= occ + OCC_W'(enq_valid_i && enq_ready_o) - OCC_W'(iss_valid_o);
      if (iss_valid_o) begin
        ck_vld[iss_bank_o] <= 1'b1;
        ck_row[iss_bank_o] <= iss_row_o;
      end
    end
  end

  p_ready_full_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enq_ready_o == (occ != OCC_W'(QDEPTH)));

  p_ready_after_issue_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enq_ready_o && iss_valid_o) |=> enq_ready_o);

  p_empty_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (occ == '0) |-> !iss_valid_o);

  p_bank_free_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iss_valid_o |-> !bank_busy_i[iss_bank_o]);

  p_hit_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iss_valid_o |-> (iss_hit_o == (ck_vld[iss_bank_o] && ck_row[iss_bank_o] == iss_row_o)));
endmodule

bind dram_req_sched dram_req_sched_chk #(
  .NUM_BANKS(NUM_BANKS), .QDEPTH(QDEPTH), .ROW_W(ROW_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bank_busy_i(bank_busy_i),
  .enq_valid_i(enq_valid_i), .enq_ready_o(enq_ready_o),
  .iss_valid_o(iss_valid_o), .iss_bank_o(iss_bank_o),
  .iss_row_o(iss_row_o), .iss_hit_o(iss_hit_o)
);

// File: tb/dram_req_sched_test.sv
`timescale 1ns/1ps
module dram_req_sched_test;
  localparam int NB = 8, QD = 16, ROW_W = 14, WARP_W = 3, REM_W = 12, AGE_W = 8, SERV_W = 8;
  localparam int NW = 1 << WARP_W;
  localparam int AGE_MAX = (1 << AGE_W) - 1;
  localparam int SERV_MAX = (1 << SERV_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] policy = 2'd0;
  logic [NB-1:0] busy = '0;
  logic enq_valid = 1'b0, enq_ready;
  logic [2:0] enq_bank = '0;
  logic [ROW_W-1:0] enq_row = '0;
  logic [WARP_W-1:0] enq_warp = '0;
  logic [REM_W-1:0] enq_rem = '0;
  logic iss_valid, iss_hit;
  logic [2:0] iss_bank;
  logic [ROW_W-1:0] iss_row;
  logic [WARP_W-1:0] iss_warp;
  logic [REM_W-1:0] iss_rem;

  always #4 clk = ~clk;

  dram_req_sched #(.NUM_BANKS(NB), .QDEPTH(QD), .ROW_W(ROW_W), .WARP_W(WARP_W),
    .REM_W(REM_W), .AGE_W(AGE_W), .SERV_W(SERV_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .policy_i(policy), .bank_busy_i(busy),
    .enq_valid_i(enq_valid), .enq_ready_o(enq_ready), .enq_bank_i(enq_bank),
    .enq_row_i(enq_row), .enq_warp_i(enq_warp), .enq_rem_i(enq_rem),
    .iss_valid_o(iss_valid), .iss_bank_o(iss_bank), .iss_row_o(iss_row),
    .iss_warp_o(iss_warp), .iss_rem_o(iss_rem), .iss_hit_o(iss_hit));

  int total = 0, bad = 0;
  bit done = 0;
  bit mv[QD];
  int mbank[QD], mrow[QD], mwarp[QD], mrem[QD], mage[QD];
  bit ovld[NB];
  int orow[NB];
  int served[NW];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit is_hit(input int i);
    return ovld[mbank[i]] && orow[mbank[i]] == mrow[i];
  endfunction

  // true when slot a outranks slot b (b scanned earlier, i.e. lower index)
  function automatic bit beats(input int a, input int b, input int pol);
    if (pol != 0 && is_hit(a) != is_hit(b)) return is_hit(a);
    if (pol == 2 && served[mwarp[a]] != served[mwarp[b]]) return served[mwarp[a]] < served[mwarp[b]];
    if (pol == 3 && mrem[a] != mrem[b]) return mrem[a] > mrem[b];
    return mage[a] > mage[b];
  endfunction

  task automatic step(input bit ev, input int b, input int r, input int w, input int rm,
                      input logic [NB-1:0] bz, input int pol);
    int best, free_slot;
    bit exp_ready;
    string ptag;
    @(negedge clk);
    enq_valid = ev; enq_bank = 3'(b); enq_row = ROW_W'(r); enq_warp = WARP_W'(w);
    enq_rem = REM_W'(rm); busy = bz; policy = 2'(pol);
    #1;
    exp_ready = 0; free_slot = -1;
    for (int i = 0; i < QD; i++) if (!mv[i] && free_slot < 0) begin free_slot = i; exp_ready = 1; end
    chk(enq_ready == exp_ready, "R1 ready", int'(enq_ready), int'(exp_ready));
    best = -1;
    for (int i = 0; i < QD; i++)
      if (mv[i] && !bz[mbank[i]] && (best < 0 || beats(i, best, pol))) best = i;
    chk(iss_valid == (best >= 0), "R2 issue valid", int'(iss_valid), int'(best >= 0));
    case (pol)
      0: ptag = "R3 R7 R11 oldest";
      1: ptag = "R4 R7 R11 hit-age";
      2: ptag = "R5 R7 R10 hit-fair";
      default: ptag = "R6 R7 hit-rem";
    endcase
    if (best >= 0 && iss_valid) begin
      chk(int'(iss_bank) == mbank[best], {ptag, " bank"}, int'(iss_bank), mbank[best]);
      chk(int'(iss_row) == mrow[best], {ptag, " row"}, int'(iss_row), mrow[best]);
      chk(int'(iss_warp) == mwarp[best], {ptag, " warp"}, int'(iss_warp), mwarp[best]);
      chk(int'(iss_rem) == mrem[best], {ptag, " rem"}, int'(iss_rem), mrem[best]);
      chk(iss_hit == is_hit(best), "R8 R9 hit flag", int'(iss_hit), int'(is_hit(best)));
    end
    @(posedge clk);
    if (best >= 0) begin
      mv[best] = 0;
      ovld[mbank[best]] = 1; orow[mbank[best]] = mrow[best];
      if (served[mwarp[best]] < SERV_MAX) served[mwarp[best]]++;
    end
    for (int i = 0; i < QD; i++) if (mv[i] && mage[i] < AGE_MAX) mage[i]++;
    if (ev && exp_ready) begin
      mv[free_slot] = 1; mbank[free_slot] = b; mrow[free_slot] = r;
      mwarp[free_slot] = w; mrem[free_slot] = rm; mage[free_slot] = 0;
    end
  endtask

  task automatic rand_step(input int pol, input int enq_pct, input int busy_pct);
    logic [NB-1:0] bz;
    for (int k = 0; k < NB; k++) bz[k] = ($urandom % 100) < busy_pct;
    step(($urandom % 100) < enq_pct, $urandom % NB, $urandom % 4, $urandom % NW,
         $urandom % 16, bz, pol);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < QD; i++) mv[i] = 0;
    for (int i = 0; i < NB; i++) begin ovld[i] = 0; orow[i] = 0; end
    for (int i = 0; i < NW; i++) served[i] = 0;
    repeat (3) @(negedge clk);
    chk(enq_ready == 1'b1, "R1 reset ready", int'(enq_ready), 1);
    chk(iss_valid == 1'b0, "R2 reset idle", int'(iss_valid), 0);
    @(negedge clk); rst_n = 1'b1;

    // R1: fill with all banks busy, overflow offer is dropped; R11 ages saturate
    for (int i = 0; i < QD + 2; i++) step(1, i % NB, i % 3, i % NW, i, '1, 0);
    for (int i = 0; i < 300; i++) step(0, 0, 0, 0, 0, '1, 0);
    // R7: all ages equal at saturation, drain oldest-first in slot order
    for (int i = 0; i < QD + 2; i++) step(0, 0, 0, 0, 0, '0, 0);

    // R4 R8 R9: hit on bank 2 beats an older miss
    step(1, 2, 5, 0, 1, 8'hFF, 1);
    step(0, 0, 0, 0, 0, 8'h00, 1);
    step(1, 2, 9, 1, 1, 8'hFF, 1);
    step(1, 2, 5, 2, 1, 8'hFF, 1);
    step(0, 0, 0, 0, 0, 8'h00, 1);
    step(0, 0, 0, 0, 0, 8'h00, 1);

    for (int p = 0; p < 4; p++) begin
      for (int i = 0; i < 1500; i++) rand_step(p, 60, 40);
      for (int i = 0; i < 40; i++) rand_step(p, 90, 100);
      for (int i = 0; i < 200; i++) rand_step(p, 30, 20);
    end
    for (int i = 0; i < 2000; i++) rand_step($urandom % 4, 70, 50);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule